// File: doc/BRIEF.md
# Serial Byte Transmitter with Enable Sequencing

This block is the sending side of an asynchronous serial port. It accepts bytes on a valid/ready handshake, keeps one byte in a holding register, and shifts each byte onto a serial line as a ten-bit frame. Every bit lasts from one baud tick to the next. The baud tick is a single-cycle strobe that the surrounding logic supplies.

Two enable inputs control the block. The global enable gates everything. When it drops, the line returns high, any frame in progress is abandoned, the held byte is thrown away and every flag clears. The transmit enable is sampled only on baud ticks. The sampled value is echoed on an acknowledge output, so software can see whether a low pulse on the enable was long enough to register.

A registered low pulse during a data frame makes the block send one all-high filler frame after the current word. In card mode there is no filler frame. Instead, a freshly raised transmit enable holds off the first frame for one extra bit time. A completion flag tells software when the line has drained, so the transmitter can be switched off cleanly. A DMA request asks for the next byte whenever one can be taken.

Top module: `uart_tx_seq`

## Requirements
- R1: Each data frame is one low start bit, then the 8 data bits least-significant first, then one high stop bit. Each bit is held from one baud tick to the next.
- R2: After reset, and at any time when no frame or filler is being sent, `txd` is 1. After reset, `tx_en_ack`, `tx_done`, `tx_ready` and `dma_req` are 0.
- R3: A byte waiting in the holding register starts on the same tick that ends the previous stop bit, so consecutive start bits are exactly 10 tick periods apart.
- R4: While `sys_en` is 1, `tx_en_ack` takes the value of `tx_en` sampled at each baud tick. A low pulse on `tx_en` that covers no baud tick leaves `tx_en_ack` at 1 and has no effect on the line.
- R5: Outside card mode, if `tx_en_ack` falls during a data frame and later rises, exactly one filler frame follows that data frame and comes before the next data frame. The filler holds the line high for 10 bit times, so the next start bit comes 20 tick periods after the previous one.
- R6: In card mode (`card_mode` = 1), the same enable pulse produces no filler frame. The next data frame still starts 10 tick periods after the previous one.
- R7: A byte offered when `tx_en` rises starts on the first tick after the tick at which `tx_en_ack` rises. In card mode it starts one bit time later, on the second such tick.
- R8: When `sys_en` is 0 at a clock edge, then after that edge `txd` is 1, `tx_en_ack`, `tx_done` and `tx_ready` are 0, the frame in progress is dropped and the held byte is discarded.
- R9: `tx_ready` and `dma_req` are 1 exactly when `sys_en` is 1, `tx_en_ack` is 1 and the holding register is empty. A byte is taken on a clock edge where both `tx_valid` and `tx_ready` are 1.
- R10: `tx_done` becomes 1 at the tick that ends a stop bit or a filler frame when no byte is held and no filler is owed. It returns to 0 one cycle after a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_en | input | 1 | Global enable; low aborts and clears |
| tx_en | input | 1 | Transmit enable, sampled on baud ticks |
| card_mode | input | 1 | 1 selects start delay instead of filler frame |
| baud_tick | input | 1 | One-cycle strobe marking bit boundaries |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial line, idle high |
| tx_en_ack | output | 1 | Effective transmit enable |
| tx_done | output | 1 | Line drained, nothing pending |
| dma_req | output | 1 | Request for the next byte |

## Verification
All line changes are registered on a baud-tick edge. A start bit therefore shows up at the first falling clock edge after the tick that launches it. The bench records that cycle and checks two things: the spacing between starts (10 or 20 tick periods), and the distance from a `tx_en` rise to the start bit. That distance is 9 cycles outside card mode and 17 in card mode, with 8-cycle ticks and `tx_en` raised just before a tick edge.

The enable pulses are placed at known tick phases. The acknowledge flag is checked one cycle after the sampling tick. The abort effects of R8 and the clearing of `tx_done` on acceptance are checked at the falling edge right after the clock edge that causes them. A scoreboard monitor samples each bit in the middle of its tick period and compares the byte with the queue that the driver fills.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

    // Shifter activity
    typedef enum logic [1:0] {
        TXS_IDLE = 2'd0,
        TXS_DATA = 2'd1,
        TXS_GAP  = 2'd2
    } txs_e;

    // What the shifter does at a frame boundary
    typedef enum logic [1:0] {
        NXT_IDLE = 2'd0,
        NXT_GAP  = 2'd1,
        NXT_DATA = 2'd2
    } nxt_e;

    // Owed filler goes out before any held byte
    function automatic nxt_e pick_next(input logic can_go,
                                       input logic gap_req,
                                       input logic have_byte);
        if (!can_go)   return NXT_IDLE;
        if (gap_req)   return NXT_GAP;
        if (have_byte) return NXT_DATA;
        return NXT_IDLE;
    endfunction

endpackage

// File: rtl/tx_enable_ctl.sv
module tx_enable_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sys_en,
    input  logic tx_en,
    input  logic card_mode,
    input  logic baud_tick,
    input  logic frame_busy,
    input  logic gap_taken,
    output logic en_ack,
    output logic start_gate,
    output logic gap_pend
);

    always_ff @(posedge clk) begin
        if (rst || !sys_en) begin
            en_ack     <= 1'b0;
            start_gate <= 1'b0;
            gap_pend   <= 1'b0;
        end else begin
            if (baud_tick) begin
                en_ack     <= tx_en;
                start_gate <= card_mode && tx_en && !en_ack;
            end
            if (gap_taken)
                gap_pend <= 1'b0;
            else if (baud_tick && en_ack && !tx_en && !card_mode && frame_busy)
                gap_pend <= 1'b1;
        end
    end

    // R7
    gate_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (start_gate && baud_tick && sys_en) |=> !start_gate);

    // R6
    card_no_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (card_mode && $stable(card_mode)) |-> !$rose(gap_pend));

    // R8
    ack_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sys_en |=> (!en_ack && !gap_pend && !start_gate));

endmodule

// File: rtl/tx_frame_shift.sv
module tx_frame_shift
    import tx_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_en,
    input  logic              baud_tick,
    input  logic              can_start,
    input  logic              have_byte,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              gap_req,
    output logic              line_out,
    output logic              take_byte,
    output logic              take_gap,
    output logic              frame_busy,
    output logic              frame_done
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CW         = $clog2(FRAME_BITS);
    localparam int LAST       = FRAME_BITS - 1;

    txs_e            st;
    logic [CW-1:0]   cnt;
    logic [DATA_W:0] sh;     // data bits then stop bit

    nxt_e nxt;
    logic at_end;
    logic ready_pt;

    always_comb begin
        nxt        = pick_next(can_start, gap_req, have_byte);
        at_end     = (st != TXS_IDLE) && (cnt == CW'(LAST));
        ready_pt   = sys_en && baud_tick && ((st == TXS_IDLE) || at_end);
        take_byte  = ready_pt && (nxt == NXT_DATA);
        take_gap   = ready_pt && (nxt == NXT_GAP);
        frame_done = ready_pt && (st != TXS_IDLE) && (nxt == NXT_IDLE)
                     && !have_byte && !gap_req;
        frame_busy = (st == TXS_DATA);
    end

    always_ff @(posedge clk) begin
        if (rst || !sys_en) begin
            st       <= TXS_IDLE;
            cnt      <= '0;
            sh       <= '0;
            line_out <= 1'b1;
        end else if (baud_tick) begin
            if (take_byte) begin
                st       <= TXS_DATA;
                cnt      <= '0;
                sh       <= {1'b1, byte_in};
                line_out <= 1'b0;
            end else if (take_gap) begin
                st       <= TXS_GAP;
                cnt      <= '0;
                line_out <= 1'b1;
            end else if (ready_pt) begin
                st       <= TXS_IDLE;
                line_out <= 1'b1;
            end else if (st != TXS_IDLE) begin
                cnt <= cnt + 1'b1;
                if (st == TXS_DATA) begin
                    line_out <= sh[0];
                    sh       <= sh >> 1;
                end
            end
        end
    end

    // R5
    gap_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TXS_GAP) |-> line_out);

    // R1
    stop_bit_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TXS_DATA && cnt == CW'(LAST)) |-> line_out);

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        (st == TXS_IDLE) |-> line_out);

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_en,
    input  logic              tx_en,
    input  logic              card_mode,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              tx_en_ack,
    output logic              tx_done,
    output logic              dma_req
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              start_gate;
    logic              gap_pend;
    logic              take_byte;
    logic              take_gap;
    logic              frame_busy;
    logic              frame_done;
    logic              accept;

    tx_enable_ctl u_en (
        .clk        (clk),
        .rst        (rst),
        .sys_en     (sys_en),
        .tx_en      (tx_en),
        .card_mode  (card_mode),
        .baud_tick  (baud_tick),
        .frame_busy (frame_busy),
        .gap_taken  (take_gap),
        .en_ack     (tx_en_ack),
        .start_gate (start_gate),
        .gap_pend   (gap_pend)
    );

    tx_frame_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .sys_en     (sys_en),
        .baud_tick  (baud_tick),
        .can_start  (tx_en_ack && !start_gate),
        .have_byte  (hold_full),
        .byte_in    (hold_data),
        .gap_req    (gap_pend),
        .line_out   (txd),
        .take_byte  (take_byte),
        .take_gap   (take_gap),
        .frame_busy (frame_busy),
        .frame_done (frame_done)
    );

    assign tx_ready = sys_en && tx_en_ack && !hold_full;
    assign dma_req  = tx_ready;
    assign accept   = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst || !sys_en) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (take_byte) begin
            hold_full <= 1'b0;
        end else if (accept) begin
            hold_full <= 1'b1;
            hold_data <= tx_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !sys_en)
            tx_done <= 1'b0;
        else if (accept)
            tx_done <= 1'b0;
        else if (frame_done)
            tx_done <= 1'b1;
    end

    // R8
    sys_off_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !sys_en |=> (txd && !tx_en_ack && !tx_done && !tx_ready));

    // R10
    accept_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !tx_done);

    // R10
    done_means_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (txd && !hold_full));

    // R9
    held_byte_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !take_byte) |=> !dma_req);

endmodule

// File: tb/sim_uart_tx_seq.sv
module sim_uart_tx_seq;

    localparam int BIT_CYC = 8;
    localparam int LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       card_mode = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd, tx_en_ack, tx_done, dma_req;

    uart_tx_seq u0 (
        .clk(clk), .rst(rst), .sys_en(sys_en), .tx_en(tx_en),
        .card_mode(card_mode), .baud_tick(baud_tick), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .tx_en_ack(tx_en_ack), .tx_done(tx_done), .dma_req(dma_req)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int tph = 0;
    always @(posedge clk) begin
        cyc       <= cyc + 1;
        tph       <= (tph == BIT_CYC - 1) ? 0 : tph + 1;
        baud_tick <= (tph == BIT_CYC - 1);
    end

    int         checks = 0;
    int         fails  = 0;
    bit         finished = 0;
    bit         mon_en = 1;
    logic [7:0] exp_q[$];
    int         starts[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Driver: queue expected byte, then hand it over on the handshake
    task automatic send_byte(input logic [7:0] b);
        exp_q.push_back(b);
        tx_data  = b;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_tick_neg();
        do @(negedge clk); while (!baud_tick);
    endtask

    task automatic wait_starts(input int n);
        while (starts.size() < n) @(negedge clk);
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        while (!tx_done) @(negedge clk);
    endtask

    // Monitor: decode frames mid-bit, compare with scoreboard queue (R1)
    initial begin : mon
        forever begin
            @(negedge clk);
            if (mon_en && txd === 1'b0) begin : frm
                logic [7:0] got;
                int         sc;
                sc = cyc;
                repeat (BIT_CYC / 2 - 1) @(negedge clk);
                chk("R1 start bit low", {31'b0, txd}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    got[i] = txd;
                end
                repeat (BIT_CYC) @(negedge clk);
                chk("R1 stop bit high", {31'b0, txd}, 32'd1);
                if (exp_q.size() == 0) begin
                    chk("R1 unexpected frame", {24'b0, got}, 32'hFFFF_FFFF);
                end else begin
                    chk("R1 frame byte", {24'b0, got}, {24'b0, exp_q.pop_front()});
                end
                starts.push_back(sc);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == LIMIT && !finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin : stim
        int n;
        int c0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset txd", {31'b0, txd}, 32'd1);
        chk("R2 reset ack", {31'b0, tx_en_ack}, 32'd0);
        chk("R2 reset done", {31'b0, tx_done}, 32'd0);
        chk("R9 reset dma", {31'b0, dma_req}, 32'd0);
        tx_en = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        chk("R9 dma off while sys_en low", {31'b0, dma_req}, 32'd0);
        chk("R4 ack low while sys_en low", {31'b0, tx_en_ack}, 32'd0);
        tx_en  = 1'b0;
        sys_en = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        chk("R9 dma off while tx_en low", {31'b0, dma_req}, 32'd0);

        // R7 non-card start latency
        wait_tick_neg();
        tx_en = 1'b1;
        c0 = cyc;
        send_byte(8'hA5);
        wait_starts(1);
        chk("R7 latency non-card", starts[0] - c0, 32'd9);
        chk("R4 ack follows enable", {31'b0, tx_en_ack}, 32'd1);

        // R3 back-to-back frames
        n = starts.size();
        send_byte(8'h3C);
        send_byte(8'h00);
        send_byte(8'hFF);
        wait_starts(n + 3);
        chk("R3 spacing a", starts[n + 1] - starts[n], 32'd80);
        chk("R3 spacing b", starts[n + 2] - starts[n + 1], 32'd80);

        // R10 done set then cleared by acceptance
        wait_done();
        chk("R10 done set", {31'b0, tx_done}, 32'd1);
        chk("R2 idle line high", {31'b0, txd}, 32'd1);
        chk("R9 dma when empty", {31'b0, dma_req}, 32'd1);
        send_byte(8'h5A);
        chk("R10 done cleared on accept", {31'b0, tx_done}, 32'd0);
        wait_done();

        // R4 short pulse missing every tick: no effect
        n = starts.size();
        send_byte(8'h11);
        send_byte(8'h22);
        wait_tick_neg();
        @(negedge clk); tx_en = 1'b0;
        @(negedge clk); tx_en = 1'b1;
        chk("R4 short pulse unseen", {31'b0, tx_en_ack}, 32'd1);
        wait_starts(n + 2);
        chk("R4 short pulse no filler", starts[n + 1] - starts[n], 32'd80);
        wait_done();

        // R5 registered pulse in normal mode: one filler frame
        n = starts.size();
        send_byte(8'h33);
        send_byte(8'h44);
        wait_tick_neg();
        tx_en = 1'b0;
        @(negedge clk);
        chk("R4 ack dropped", {31'b0, tx_en_ack}, 32'd0);
        wait_tick_neg();
        tx_en = 1'b1;
        @(negedge clk);
        chk("R4 ack restored", {31'b0, tx_en_ack}, 32'd1);
        wait_starts(n + 2);
        chk("R5 filler spacing", starts[n + 1] - starts[n], 32'd160);
        wait_done();

        // R6 same pulse in card mode: no filler
        card_mode = 1'b1;
        n = starts.size();
        send_byte(8'h55);
        send_byte(8'h77);
        wait_tick_neg();
        tx_en = 1'b0;
        wait_tick_neg();
        tx_en = 1'b1;
        wait_starts(n + 2);
        chk("R6 card no filler", starts[n + 1] - starts[n], 32'd80);
        wait_done();

        // R7 card mode start delay
        tx_en = 1'b0;
        wait_tick_neg();
        wait_tick_neg();
        wait_tick_neg();
        tx_en = 1'b1;
        c0 = cyc;
        n = starts.size();
        send_byte(8'h66);
        wait_starts(n + 1);
        chk("R7 latency card", starts[n] - c0, 32'd17);
        wait_done();

        // R8 abort by global enable
        card_mode = 1'b0;
        mon_en = 1'b0;
        tx_data  = 8'h00;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        while (txd) @(negedge clk);
        repeat (20) @(negedge clk);
        sys_en = 1'b0;
        @(negedge clk);
        chk("R8 line high", {31'b0, txd}, 32'd1);
        chk("R8 ack cleared", {31'b0, tx_en_ack}, 32'd0);
        chk("R8 done cleared", {31'b0, tx_done}, 32'd0);
        chk("R9 dma off on abort", {31'b0, dma_req}, 32'd0);
        chk("R8 ready off", {31'b0, tx_ready}, 32'd0);
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 3 * BIT_CYC; i++) begin
                @(negedge clk);
                if (txd !== 1'b1 || dma_req !== 1'b0) lows++;
            end
            chk("R8 quiet while disabled", lows, 32'd0);
        end
        sys_en = 1'b1;
        mon_en = 1'b1;
        n = starts.size();
        send_byte(8'h81);   // held byte from abort must not appear
        wait_done();
        chk("R8 only new byte sent", starts.size() - n, 32'd1);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule